// File: doc/BRIEF.md
# Run-time Configurable UART Transmitter

This block serialises one character per accepted write onto an asynchronous serial line that rests high. The layout of each character is set at run time: five to eight data bits, an optional parity bit whose sense can be chosen, and one or two stop bits. The layout inputs and the data byte are sampled together with the write and held for the whole character. Changing them while a character is on the line therefore cannot corrupt it.

Bit timing comes from a tick at sixteen times the bit rate. An internal phase-accumulating divider makes that tick from the system clock and a 17-bit binary value that holds the rate in bits per second. The tick is a multi-cycle square wave. The engine counts only its rising edges, which it finds with a two-stage shift register. Every serial bit spans sixteen of those edges. A parent block issues a write only while `busy` is low, and it may treat the fall of `busy` as the end of the character on the wire.

Top module: `uart_cfg_tx`

## Requirements
- R1: After reset the line is high and busy is low. The line stays high whenever busy is low.
- R2: An accepted write starts the character with a low start bit in the next clock. Every later bit lasts exactly 16 rising edges of the 16x tick.
- R3: The data bits follow the start bit least significant bit first. Their count is the data-length input, limited to 5..8: values below 5 give 5 bits and values above 8 give 8 bits. Only that many low bits of the byte are sent.
- R4: When parity is enabled (parity_en=1), one parity bit follows the data. Its value is the XOR of the transmitted data bits XORed with parity_mode. When parity_en=0 no parity bit is sent.
- R5: The stop bits are high. Two stop bits are sent when bit 1 of stop_len is set (values 2 and 3), and one is sent otherwise (values 0 and 1).
- R6: busy rises in the clock after an accepted write. It stays high until the last stop bit ends, so the character occupies (1 + data bits + parity bits + stop bits) bit times.
- R7: A write while busy is ignored and no character is queued. Changes to the data or layout inputs during a character leave that character unchanged.
- R8: The 16x tick repeats at 16 times baud_rate. With a 7_372_800 Hz clock, rate 115200 gives 64-clock bits and rate 57600 gives 128-clock bits. A tick high for several clocks counts once.
- R9: The asynchronous active-low reset forces the line high and busy low at once, even in the middle of a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_rate | input | 17 | Bit rate in bits per second, binary |
| wr_en | input | 1 | Write strobe, accepted when busy is low |
| wr_data | input | 8 | Character to send |
| data_len | input | 4 | Number of data bits, 5..8, clamped |
| stop_len | input | 2 | Stop-bit count select, bit 1 set gives two |
| parity_en | input | 1 | 1 adds a parity bit |
| parity_mode | input | 1 | Value XORed into the parity bit |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | High while a character is being sent |

## Verification
The hardest case to reach is a write, and new layout inputs, arriving while a character is already on the line. Right after the start bit appears, the stimulus drives an inverted byte, a different length, a different stop setting and inverted parity controls, and pulses write. It then checks every bit of the running character against the originally sampled values. It also watches the line for two bit times after busy falls, to show that no second character was queued. A sweep covers every length code from 4 to 9 combined with every parity and stop setting. Separate cases cover a second bit rate and a reset that lands mid-character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [2:0] last_bit;
    logic       par_on;
    logic       two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/baud16_gen.sv
module baud16_gen #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RATE_W = 17,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              tick_lvl
);
  localparam int OSR_W = $clog2(OSR);
  localparam int HZ_W  = $clog2(CLK_HZ);
  localparam int ACC_W = ((HZ_W > RATE_W + OSR_W) ? HZ_W : RATE_W + OSR_W) + 1;

  logic [ACC_W-1:0] acc_q, acc_n, step, sum;

  always_comb begin
    step  = ACC_W'({rate, {OSR_W{1'b0}}});
    sum   = acc_q + step;
    acc_n = (sum >= ACC_W'(CLK_HZ)) ? sum - ACC_W'(CLK_HZ) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign tick_lvl = (acc_q >= ACC_W'(CLK_HZ / 2));

  p_acc_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(CLK_HZ));

endmodule

// File: rtl/tick_edge_det.sv
module tick_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_lvl,
  output logic tick_rise
);
  logic [1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 2'b00;
    else        hist_q <= {hist_q[0], tick_lvl};
  end

  assign tick_rise = (hist_q == 2'b01);

  p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int OSR     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_rise,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        len_sel,
  input  logic [1:0]        stop_sel,
  input  logic              par_en,
  input  logic              par_mode,
  output logic              tx,
  output logic              busy
);
  localparam int TCNT_W = $clog2(OSR);
  localparam int IDX_W  = $clog2(DATA_W);

  tx_state_e         st_q, st_n;
  logic [TCNT_W-1:0] tcnt_q, tcnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n, mask;
  logic              par_q, par_n, tx_q, tx_n, bit_end;
  frame_cfg_t        cfg_q, cfg_n;
  int                len_eff;

  always_comb begin
    len_eff = (int'(len_sel) < MIN_LEN) ? MIN_LEN :
              (int'(len_sel) > DATA_W) ? DATA_W : int'(len_sel);
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < len_eff);
  end

  always_comb begin
    st_n    = st_q;
    tcnt_n  = tcnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    par_n   = par_q;
    cfg_n   = cfg_q;
    bit_end = tick_rise && (tcnt_q == TCNT_W'(OSR - 1));
    if (tick_rise) tcnt_n = bit_end ? '0 : tcnt_q + 1'b1;
    case (st_q)
      ST_IDLE: begin
        tcnt_n = '0;
        idx_n  = '0;
        if (wr_en) begin
          st_n           = ST_START;
          sh_n           = wr_data & mask;
          par_n          = (^(wr_data & mask)) ^ par_mode;
          cfg_n.last_bit = 3'(len_eff - 1);
          cfg_n.par_on   = par_en;
          cfg_n.two_stop = stop_sel[1];
        end
      end
      ST_START: if (bit_end) st_n = ST_DATA;
      ST_DATA: if (bit_end) begin
        sh_n  = sh_q >> 1;
        idx_n = idx_q + 1'b1;
        if (idx_q == IDX_W'(cfg_q.last_bit)) begin
          idx_n = '0;
          st_n  = cfg_q.par_on ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: if (bit_end) st_n = ST_STOP;
      ST_STOP: if (bit_end) begin
        if (cfg_q.two_stop && idx_q == '0) idx_n = IDX_W'(1);
        else st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    case (st_n)
      ST_START: tx_n = 1'b0;
      ST_DATA:  tx_n = sh_n[0];
      ST_PAR:   tx_n = par_q;
      default:  tx_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      cfg_q  <= '0;
      tx_q   <= 1'b1;
    end else begin
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
      cfg_q  <= cfg_n;
      tx_q   <= tx_n;
    end
  end

  assign tx   = tx_q;
  assign busy = (st_q != ST_IDLE);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en) |=> busy);
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));
  p_tick_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_rise) |=> $stable(tcnt_q));

endmodule

// File: rtl/uart_cfg_tx.sv
module uart_cfg_tx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RATE_W = 17,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] baud_rate,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        data_len,
  input  logic [1:0]        stop_len,
  input  logic              parity_en,
  input  logic              parity_mode,
  output logic              tx_line,
  output logic              busy
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n, tick_lvl, tick_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  baud16_gen #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W), .OSR(OSR)) i_div (
    .clk(clk), .rst_n(rst_int_n), .rate(baud_rate), .tick_lvl(tick_lvl));

  tick_edge_det i_edge (
    .clk(clk), .rst_n(rst_int_n), .tick_lvl(tick_lvl), .tick_rise(tick_rise));

  uart_tx_engine #(.DATA_W(DATA_W), .OSR(OSR)) i_eng (
    .clk(clk), .rst_n(rst_int_n), .tick_rise(tick_rise),
    .wr_en(wr_en), .wr_data(wr_data), .len_sel(data_len),
    .stop_sel(stop_len), .par_en(parity_en), .par_mode(parity_mode),
    .tx(tx_line), .busy(busy));

endmodule

// File: tb/test_uart_cfg_tx.sv
module test_uart_cfg_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] baud = 17'd115200;
  logic        wr = 1'b0;
  logic [7:0]  din = '0;
  logic [3:0]  dlen = 4'd8;
  logic [1:0]  slen = 2'd1;
  logic        pen = 1'b1, pmode = 1'b0;
  logic        tx, busy;
  int          tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  uart_cfg_tx #(.CLK_HZ(7_372_800)) i_uart_cfg_tx (
    .clk(clk), .rst_n(rst_n), .baud_rate(baud), .wr_en(wr), .wr_data(din),
    .data_len(dlen), .stop_len(slen), .parity_en(pen), .parity_mode(pmode),
    .tx_line(tx), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_watch(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!tx || busy) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [3:0] ln, input logic [1:0] sl,
                           input logic pe, input logic pm, input bit inject,
                           input int bp, input int tp);
    int L, n, t, tgt;
    logic [7:0] m;
    logic expb;
    bit found = 0;
    L = (ln < 5) ? 5 : ((ln > 8) ? 8 : int'(ln));
    n = 1 + L + int'(pe) + (sl[1] ? 2 : 1);
    m = 8'((1 << L) - 1);
    @(negedge clk);
    din = d; dlen = ln; slen = sl; pen = pe; pmode = pm; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk(busy == 1'b1, "R6 busy after write", busy, 1);
    for (int i = 0; i < 50; i++) begin
      if (!tx) begin found = 1; break; end
      @(negedge clk);
    end
    chk(found, "R2 start edge", found, 1);
    t = 0;
    if (inject) begin
      din = ~d; dlen = (ln == 4'd5) ? 4'd8 : 4'd5; slen = ~sl; pen = ~pe; pmode = ~pm;
      wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      t = 1;
    end
    for (int k = 0; k < n; k++) begin
      tgt = bp * k + bp / 2 - tp;
      while (t < tgt) begin @(negedge clk); t++; end
      if (k == 0) begin
        expb = 1'b0;
        chk(tx == expb, "R2 start bit", tx, expb);
      end else if (k <= L) begin
        expb = d[k-1];
        chk(tx == expb, inject ? "R7 data bit under write" : "R3 data bit", tx, expb);
      end else if (k == L + 1 && pe) begin
        expb = (^(d & m)) ^ pm;
        chk(tx == expb, "R4 parity bit", tx, expb);
      end else begin
        expb = 1'b1;
        chk(tx == expb, "R5 stop bit", tx, expb);
      end
      chk(busy == 1'b1, "R6 busy during frame", busy, 1);
    end
    while (busy && t < bp * n + 50) begin @(negedge clk); t++; end
    chk(t >= bp * n - tp - 2 && t <= bp * n + 2, "R6 frame length", t, bp * n);
    if (inject) idle_watch(2 * bp, "R7 no queued frame");
    else repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx == 1'b1, "R1 line high in reset", tx, 1);
    chk(busy == 1'b0, "R1 busy low in reset", busy, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_watch(100, "R1 idle after reset");

    // R3 R4 R5: sweep of length codes 4..9, parity and stop settings
    for (int ln = 4; ln <= 9; ln++)
      for (int pe = 0; pe < 2; pe++)
        for (int pm = 0; pm < 2; pm++)
          for (int sl = 0; sl < 4; sl++)
            run_frame(8'((ln * 53 + pe * 29 + pm * 71 + sl * 17 + 11) & 8'hFF),
                      4'(ln), 2'(sl), 1'(pe), 1'(pm), 1'b0, 64, 4);

    // R3 R4: corner data patterns in the default layout
    run_frame(8'h00, 4'd8, 2'd1, 1'b1, 1'b0, 1'b0, 64, 4);
    run_frame(8'hFF, 4'd8, 2'd1, 1'b1, 1'b0, 1'b0, 64, 4);
    run_frame(8'hA5, 4'd8, 2'd1, 1'b1, 1'b1, 1'b0, 64, 4);

    // R7: write and layout changes during a frame
    run_frame(8'h5A, 4'd8, 2'd1, 1'b1, 1'b0, 1'b1, 64, 4);
    run_frame(8'h3C, 4'd5, 2'd2, 1'b0, 1'b1, 1'b1, 64, 4);

    // R8: half the bit rate doubles the bit time
    baud = 17'd57600;
    repeat (20) @(negedge clk);
    run_frame(8'hC3, 4'd7, 2'd2, 1'b1, 1'b1, 1'b0, 128, 8);
    baud = 17'd115200;
    repeat (20) @(negedge clk);

    // R9: asynchronous reset in the middle of a frame
    @(negedge clk);
    din = 8'h00; dlen = 4'd8; slen = 2'd1; pen = 1'b1; pmode = 1'b0; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(tx == 1'b1, "R9 line high on reset", tx, 1);
    chk(busy == 1'b0, "R9 busy low on reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_watch(200, "R9 idle after mid-frame reset");
    run_frame(8'h96, 4'd8, 2'd1, 1'b1, 1'b0, 1'b0, 64, 4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule